// File: doc/BRIEF.md
# Interleaved Bank Sweep Controller

This block generates the addressing and strobes for a worker that copies or rewrites operands held in dual-half banks. Each destination word has an X half and a Y half, and the bank accepts a write only when both halves are written together. To update one half without losing the other, the controller gives every address two read slots: first the source bank is read, then the destination bank. One cycle after the destination slot, it issues a write to the same address. Control bits tell the datapath which half takes the new value and which half takes the value just read back from the destination.

One fixed sweep serves every operation. An opcode-derived input says whether the destination read is needed. When it is not, the destination read enable stays low in its slot, but all other timing is unchanged. The operating mode is captured when a sweep is accepted, and a one-cycle done pulse follows the final write. The data values themselves never pass through this block.

Top module: `ilv_sweep_ctl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `busy`, `done`, `src_rd_en`, `dst_rd_en` and `dst_wr_en` are all low.
- R2: When `start` is sampled high while idle, the source bank is read at addresses 0, 1, …, N-1, one address every second cycle. The first source read occurs in the cycle right after the accepting clock edge.
- R3: When the captured `need_dst` is 1, `dst_rd_en` is high in the cycle after each source read, at the same address.
- R4: When the captured `need_dst` is 0, `dst_rd_en` never rises during the sweep, and the source-read, write and done timing is identical to the `need_dst`=1 case.
- R5: The write for address k (`dst_wr_en` high, `dst_wr_addr`=k) is issued two cycles after the source read of address k. Reads and writes therefore overlap: the write of address k shares a cycle with the source read of address k+1. Each address is written exactly once per sweep.
- R6: `wr_sel` selects the write mode, reported on `wr_x_new`/`wr_y_new` during writes. 2'b01 gives X new and Y kept (1/0). 2'b10 gives Y new and X kept (0/1). Both 2'b11 and 2'b00 give both halves new (1/1).
- R7: `done` is high for exactly one cycle, in the cycle after the final write. `busy` is high from the first source read through the done cycle, so a sweep of N words occupies 2N+2 cycles.
- R8: A `start` sampled while `busy` is high, including in the done cycle, is ignored. `need_dst` and `wr_sel` are sampled only at the accepting edge, and later changes do not affect the running sweep.
- R9: `src_rd_en` and `dst_rd_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a sweep (accepted only when idle) |
| need_dst | input | 1 | Operation needs the destination read |
| wr_sel | input | 2 | Write mode: 01 X only, 10 Y only, 11/00 both |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse after the last write |
| src_rd_en | output | 1 | Source bank read enable |
| src_addr | output | ADDR_W | Source bank read address |
| dst_rd_en | output | 1 | Destination bank read enable |
| dst_rd_addr | output | ADDR_W | Destination bank read address |
| dst_wr_en | output | 1 | Destination bank write enable (both halves) |
| dst_wr_addr | output | ADDR_W | Destination bank write address |
| wr_x_new | output | 1 | X half takes new data (else read-back) |
| wr_y_new | output | 1 | Y half takes new data (else read-back) |

## Verification
The hardest cases to reach are a `start` arriving in the done cycle and mode inputs that change while a sweep runs. In normal use, neither happens unless a driver is careless. The stimulus raises `start` exactly in the done cycle and again mid-sweep, and it inverts `need_dst` and `wr_sel` right after acceptance. It then compares every strobe, address and mode bit against a cycle-indexed model. The bench uses a non-power-of-two word count, so the address counter must stop at N-1 rather than at a wrap. A reset applied mid-sweep is also checked.

// File: rtl/sweep_ctl_pkg.sv
package sweep_ctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SWEEP = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } sweep_state_e;

    localparam logic [1:0] WSEL_X_ONLY = 2'b01;
    localparam logic [1:0] WSEL_Y_ONLY = 2'b10;

    typedef struct packed {
        logic need_dst;
        logic x_new;
        logic y_new;
    } sweep_mode_t;

    function automatic sweep_mode_t decode_mode(input logic need, input logic [1:0] sel);
        sweep_mode_t m;
        m.need_dst = need;
        case (sel)
            WSEL_X_ONLY: begin m.x_new = 1'b1; m.y_new = 1'b0; end
            WSEL_Y_ONLY: begin m.x_new = 1'b0; m.y_new = 1'b1; end
            default:     begin m.x_new = 1'b1; m.y_new = 1'b1; end
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sweep_sequencer.sv
module sweep_sequencer
    import sweep_ctl_pkg::*;
#(
    parameter int N_WORDS = 8,
    parameter int ADDR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output sweep_state_e      state,
    output logic [ADDR_W-1:0] addr,
    output logic              phase,
    output logic              accept
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(N_WORDS - 1);

    typedef struct packed {
        sweep_state_e      state;
        logic [ADDR_W-1:0] addr;
        logic              phase;
    } seq_t;

    seq_t seq_d, seq_q;
    logic accept_d;

    always_comb begin
        seq_d    = seq_q;
        accept_d = 1'b0;
        case (seq_q.state)
            ST_IDLE: begin
                if (start) begin
                    seq_d.state = ST_SWEEP;
                    seq_d.addr  = '0;
                    seq_d.phase = 1'b0;
                    accept_d    = 1'b1;
                end
            end
            ST_SWEEP: begin
                if (!seq_q.phase) begin
                    seq_d.phase = 1'b1;
                end else begin
                    seq_d.phase = 1'b0;
                    if (seq_q.addr == LAST_ADDR) begin
                        seq_d.state = ST_DRAIN;
                    end else begin
                        seq_d.addr = seq_q.addr + ADDR_W'(1);
                    end
                end
            end
            ST_DRAIN: seq_d.state = ST_DONE;
            default:  seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, addr: '0, phase: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state  = seq_q.state;
    assign addr   = seq_q.addr;
    assign phase  = seq_q.phase;
    assign accept = accept_d;

    // R2: the address never passes the last word during the sweep
    p_addr_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_SWEEP) |-> (seq_q.addr <= LAST_ADDR));

    // R7: draining only begins after the last address's second slot
    p_drain_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_SWEEP && seq_q.phase && seq_q.addr == LAST_ADDR)
        |=> (seq_q.state == ST_DRAIN));

endmodule

// File: rtl/sweep_mode_latch.sv
module sweep_mode_latch
    import sweep_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        capture,
    input  logic        need_dst,
    input  logic [1:0]  wr_sel,
    output sweep_mode_t mode
);
    sweep_mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (capture) begin
            mode_d = decode_mode(need_dst, wr_sel);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode = mode_q;

    // R6: at least one half always takes new data after a capture
    p_some_half_new_r6: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (mode_q.x_new || mode_q.y_new));

endmodule

// File: rtl/sweep_write_stage.sv
module sweep_write_stage #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } wr_t;

    wr_t wr_d, wr_q;

    always_comb begin
        wr_d.valid = issue;
        wr_d.addr  = issue ? addr_in : wr_q.addr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
        end else begin
            wr_q <= wr_d;
        end
    end

    assign wr_en   = wr_q.valid;
    assign wr_addr = wr_q.addr;

    // R5: two write slots never come back to back
    p_no_back_to_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q.valid |=> !wr_q.valid);

endmodule

// File: rtl/ilv_sweep_ctl.sv
module ilv_sweep_ctl
    import sweep_ctl_pkg::*;
#(
    parameter int N_WORDS = 8,
    parameter int ADDR_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              need_dst,
    input  logic [1:0]        wr_sel,
    output logic              busy,
    output logic              done,
    output logic              src_rd_en,
    output logic [ADDR_W-1:0] src_addr,
    output logic              dst_rd_en,
    output logic [ADDR_W-1:0] dst_rd_addr,
    output logic              dst_wr_en,
    output logic [ADDR_W-1:0] dst_wr_addr,
    output logic              wr_x_new,
    output logic              wr_y_new
);
    sweep_state_e      state;
    logic [ADDR_W-1:0] addr;
    logic              phase;
    logic              accept;
    sweep_mode_t       mode;
    logic              slot_b;

    sweep_sequencer #(.N_WORDS(N_WORDS), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .state(state), .addr(addr), .phase(phase), .accept(accept)
    );

    sweep_mode_latch u_mode (
        .clk(clk), .rst_n(rst_n), .capture(accept),
        .need_dst(need_dst), .wr_sel(wr_sel), .mode(mode)
    );

    assign slot_b = (state == ST_SWEEP) && phase;

    sweep_write_stage #(.ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .issue(slot_b), .addr_in(addr),
        .wr_en(dst_wr_en), .wr_addr(dst_wr_addr)
    );

    assign src_rd_en   = (state == ST_SWEEP) && !phase;
    assign src_addr    = addr;
    assign dst_rd_en   = slot_b && mode.need_dst;
    assign dst_rd_addr = addr;
    assign wr_x_new    = mode.x_new;
    assign wr_y_new    = mode.y_new;
    assign busy        = (state != ST_IDLE);
    assign done        = (state == ST_DONE);

    // R9: only one bank read per cycle
    p_rd_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_rd_en && dst_rd_en));

    // R3: a destination read follows a source read of the same address
    p_dst_follows_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd_en && mode.need_dst |=> dst_rd_en && (dst_rd_addr == $past(src_addr)));

    // R5: a write lands two cycles after the source read of its address
    p_wr_after_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        src_rd_en |=> ##1 dst_wr_en && (dst_wr_addr == $past(src_addr, 2)));

    // R7: done is one cycle long and directly follows a write
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(dst_wr_en) ##1 !done && !busy);

    // R8: the captured mode holds for the whole sweep
    p_mode_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(wr_x_new) && $stable(wr_y_new) && $stable(mode.need_dst));

endmodule

// File: tb/tb_ilv_sweep_ctl.sv
module tb_ilv_sweep_ctl;
    localparam int NW = 5;
    localparam int AW = $clog2(NW);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic need_dst = 1'b0;
    logic [1:0] wr_sel = 2'b00;
    logic busy, done, src_rd_en, dst_rd_en, dst_wr_en, wr_x_new, wr_y_new;
    logic [AW-1:0] src_addr, dst_rd_addr, dst_wr_addr;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ilv_sweep_ctl #(.N_WORDS(NW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .need_dst(need_dst), .wr_sel(wr_sel),
        .busy(busy), .done(done), .src_rd_en(src_rd_en), .src_addr(src_addr),
        .dst_rd_en(dst_rd_en), .dst_rd_addr(dst_rd_addr), .dst_wr_en(dst_wr_en),
        .dst_wr_addr(dst_wr_addr), .wr_x_new(wr_x_new), .wr_y_new(wr_y_new)
    );

    // {need_dst, wr_sel[1:0], expected x_new, expected y_new}  (R6 encodings)
    localparam logic [4:0] VEC [6] = '{
        {1'b1, 2'b01, 1'b1, 1'b0},
        {1'b1, 2'b10, 1'b0, 1'b1},
        {1'b0, 2'b11, 1'b1, 1'b1},
        {1'b1, 2'b00, 1'b1, 1'b1},
        {1'b0, 2'b01, 1'b1, 1'b0},
        {1'b0, 2'b10, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    task automatic check_quiet(input string req);
        chk({req, " busy"}, 32'(busy), 0);
        chk({req, " done"}, 32'(done), 0);
        chk({req, " src_rd_en"}, 32'(src_rd_en), 0);
        chk({req, " dst_rd_en"}, 32'(dst_rd_en), 0);
        chk({req, " dst_wr_en"}, 32'(dst_wr_en), 0);
    endtask

    task automatic run_sweep(input logic need, input logic [1:0] sel, input logic ex,
                             input logic ey, input bit scramble, input bit start_in_done);
        @(negedge clk);
        start = 1'b1; need_dst = need; wr_sel = sel;
        for (int t = 0; t <= 2*NW + 2; t++) begin
            @(negedge clk);
            if (t == 0) begin
                start = 1'b0;
                if (scramble) begin need_dst = ~need; wr_sel = ~sel; end  // R8
            end
            if (scramble && t == 3) start = 1'b1;                       // R8 mid-sweep
            if (scramble && t == 4) start = 1'b0;
            if (start_in_done && t == 2*NW + 1) start = 1'b1;          // R8 done cycle
            if (start_in_done && t == 2*NW + 2) start = 1'b0;
            // R2 source reads
            chk("R2 src_rd_en", 32'(src_rd_en), 32'((t < 2*NW) && (t % 2 == 0)));
            if ((t < 2*NW) && (t % 2 == 0)) chk("R2 src_addr", 32'(src_addr), 32'(t / 2));
            // R3/R4 destination reads
            chk(need ? "R3 dst_rd_en" : "R4 dst_rd_en", 32'(dst_rd_en),
                32'(need && (t < 2*NW) && (t % 2 == 1)));
            if (need && (t < 2*NW) && (t % 2 == 1))
                chk("R3 dst_rd_addr", 32'(dst_rd_addr), 32'((t - 1) / 2));
            // R5 writes
            chk("R5 dst_wr_en", 32'(dst_wr_en), 32'((t >= 2) && (t <= 2*NW) && (t % 2 == 0)));
            if ((t >= 2) && (t <= 2*NW) && (t % 2 == 0)) begin
                chk("R5 dst_wr_addr", 32'(dst_wr_addr), 32'(t / 2 - 1));
                chk("R6 wr_x_new", 32'(wr_x_new), 32'(ex));
                chk("R6 wr_y_new", 32'(wr_y_new), 32'(ey));
            end
            // R7 done and busy
            chk("R7 done", 32'(done), 32'(t == 2*NW + 1));
            chk("R7 busy", 32'(busy), 32'(t <= 2*NW + 1));
        end
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet during reset and just after release
        repeat (3) @(negedge clk);
        check_quiet("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R1 after reset");

        // vector table walk
        for (int i = 0; i < 6; i++) begin
            run_sweep(VEC[i][4], VEC[i][3:2], VEC[i][1], VEC[i][0], 1'b0, 1'b0);
        end

        // R8: inputs scrambled mid-sweep and start raised while busy
        run_sweep(1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0);
        run_sweep(1'b0, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0);

        // R8/R7: start in done cycle is ignored; the sweep after is normal
        run_sweep(1'b1, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        check_quiet("R8 start in done ignored");
        run_sweep(1'b1, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0);

        // R1: reset mid-sweep clears every strobe
        @(negedge clk);
        start = 1'b1; need_dst = 1'b1; wr_sel = 2'b11;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_quiet("R1 mid-sweep reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R1 after mid-sweep reset");
        run_sweep(1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        finished = 1'b1;
        $finish;
    end

endmodule